// File: doc/BRIEF.md
# Double-Buffered Two-Channel DAC Register Front End

This block is the digital side of a two-channel digital-to-analog converter that sits on a parallel bus. A host drives a data word, a select bit and an active-low chip select, then pulses an active-low write strobe. When the strobe goes back high, the word lands in the staging register of the channel picked by the select bit. The staging registers feed nothing directly. A separate active-low load strobe moves both staged words into the code registers that drive the converters, so the two outputs always change together.

All bus and control pins are asynchronous to the block clock. The block synchronizes them before use. An active-low clear input empties every register at once without waiting for a clock edge, and it outranks writes and loads. An active-low sleep input drops a per-channel live flag while keeping all stored codes. The code width is a parameter.

Top module: `dbdac_regif`

## Requirements
- R1: While `rst_n` is low, both codes are zero and both live flags are low. After reset is released with `sleep_n` high, the live flags rise and the codes stay zero until a word is both written and loaded.
- R2: A write strobe issued while `bus_cs_n` is high changes no register. A later load still shows the earlier values.
- R3: `bus_sel` = 0 directs a write to channel A and `bus_sel` = 1 directs it to channel B. The other channel's staging register is untouched.
- R4: With `load_n` held high, a write does not change either output code.
- R5: A low level on `load_n` copies both staging registers into both code registers on the same clock edge.
- R6: A low level on `clear_n` zeroes both staging and both code registers immediately, without a clock edge. A write completed while clear is low is discarded.
- R7: While `load_n` is held low, a completed write reaches the addressed output code directly.
- R8: Low `sleep_n` drives both live flags low and leaves both codes unchanged. Raising it again restores the live flags, and the same codes are shown.
- R9: `load_n` falling between two clock edges changes the codes on the third rising edge after the fall, and not on the second. A write takes effect on the third rising edge after `bus_wr_n` rises.
- R10: `DATA_W` sets the code width and supports 8, 10 and 12. An 8-bit instance keeps the low 8 bits of the bus word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe; the word is taken on its rising edge |
| bus_sel | input | 1 | Channel select: 0 = A, 1 = B |
| bus_data | input | DATA_W | Data word |
| load_n | input | 1 | Active-low, level-sensitive load of both code registers |
| clear_n | input | 1 | Active-low asynchronous clear of all registers |
| sleep_n | input | 1 | Active-low low-power request |
| code_a | output | DATA_W | Channel A code register |
| code_b | output | DATA_W | Channel B code register |
| live_a | output | 1 | Channel A active flag |
| live_b | output | 1 | Channel B active flag |

## Verification
The checker watches four things on every cycle:
- the code registers hold still whenever no load is enabled;
- after an enabled load, both codes equal their staging registers;
- a staging register changes only on a write enable aimed at it;
- a low clear leaves every register at zero, and sleep clears the live flags.

Only the bench scenarios can show the following:
- the end-to-end path from the bus pins through the synchronizers;
- the exact three-edge latencies;
- the dropping of a deselected write or of a write issued during clear;
- the return of the codes after sleep;
- the 8-bit truncation.

// File: rtl/dbdac_pkg.sv
package dbdac_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int NUM_CH      = 2;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } ch_e;

    // bit positions inside the synchronized control vector
    localparam int CTL_LOAD  = 0;
    localparam int CTL_CLEAR = 1;
    localparam int CTL_SLEEP = 2;
    localparam int CTL_NUM   = 3;

endpackage

// File: rtl/dbdac_sync.sv
module dbdac_sync #(
    parameter int                  WIDTH     = 1,
    parameter int                  STAGES    = 2,
    parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbdac_capture.sv
module dbdac_capture
    import dbdac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_fire,
    output ch_e               wr_sel,
    output logic [DATA_W-1:0] wr_word
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0]             wr;
        logic                               wr_last;
        logic [SYNC_STAGES-1:0]             cs_n;
        logic [SYNC_STAGES-1:0]             sel;
        logic [SYNC_STAGES-1:0][DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;
    logic wr_rise;

    always_comb begin
        cap_d         = cap_q;
        cap_d.wr      = {cap_q.wr[TOP-1:0], bus_wr_n};
        cap_d.wr_last = cap_q.wr[TOP];
        cap_d.cs_n    = {cap_q.cs_n[TOP-1:0], bus_cs_n};
        cap_d.sel     = {cap_q.sel[TOP-1:0], bus_sel};
        for (int s = 1; s < SYNC_STAGES; s++) begin
            cap_d.data[s] = cap_q.data[s-1];
        end
        cap_d.data[0] = bus_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.wr      <= '1;
            cap_q.wr_last <= 1'b1;
            cap_q.cs_n    <= '1;
            cap_q.sel     <= '0;
            cap_q.data    <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // the strobe's end (low-to-high) marks the capture point
    assign wr_rise = cap_q.wr[TOP] & ~cap_q.wr_last;
    assign wr_fire = wr_rise & ~cap_q.cs_n[TOP];
    assign wr_sel  = ch_e'(cap_q.sel[TOP]);
    assign wr_word = cap_q.data[TOP];

endmodule

// File: rtl/dbdac_channel.sv
module dbdac_channel #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              wr_en,
    input  logic              load_en,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] in_code,
    output logic [DATA_W-1:0] dac_code
);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] dac;
    } chan_t;

    chan_t ch_d;
    chan_t ch_q;

    always_comb begin
        ch_d = ch_q;
        if (wr_en) begin
            ch_d.stage = wr_word;
        end
        // transparent while loading: a write in the same cycle passes straight through
        if (load_en) begin
            ch_d.dac = ch_d.stage;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign in_code  = ch_q.stage;
    assign dac_code = ch_q.dac;

endmodule

// File: rtl/dbdac_regif.sv
module dbdac_regif
    import dbdac_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              sleep_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              live_a,
    output logic              live_b
);

    localparam logic [CTL_NUM-1:0] CTL_RESET = CTL_NUM'(1) << CTL_LOAD;

    typedef struct packed {
        logic [NUM_CH-1:0] live;
    } top_t;

    logic [CTL_NUM-1:0]      ctl_raw;
    logic [CTL_NUM-1:0]      ctl_s;
    logic                    wr_fire;
    ch_e                     wr_sel;
    logic [DATA_W-1:0]       wr_word;
    logic                    clr_ok;
    logic                    load_en;
    logic                    sleep_s;
    logic                    arst_n;
    logic [NUM_CH-1:0]       wr_en;
    logic [DATA_W-1:0]       in_code  [NUM_CH];
    logic [DATA_W-1:0]       dac_code [NUM_CH];
    top_t                    top_d;
    top_t                    top_q;

    always_comb begin
        ctl_raw            = '0;
        ctl_raw[CTL_LOAD]  = load_n;
        ctl_raw[CTL_CLEAR] = clear_n;
        ctl_raw[CTL_SLEEP] = sleep_n;
    end

    dbdac_sync #(
        .WIDTH     (CTL_NUM),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CTL_RESET)
    ) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_s)
    );

    dbdac_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (bus_cs_n),
        .bus_wr_n (bus_wr_n),
        .bus_sel  (bus_sel),
        .bus_data (bus_data),
        .wr_fire  (wr_fire),
        .wr_sel   (wr_sel),
        .wr_word  (wr_word)
    );

    // clear outranks everything: the registers are held asynchronously,
    // and the synchronized copy blocks writes and loads until release settles
    assign clr_ok  = ctl_s[CTL_CLEAR];
    assign load_en = ~ctl_s[CTL_LOAD] & clr_ok;
    assign sleep_s = ctl_s[CTL_SLEEP];
    assign arst_n  = rst_n & clear_n;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign wr_en[i] = wr_fire & clr_ok & (wr_sel == ch_e'(i));

            dbdac_channel #(
                .DATA_W (DATA_W)
            ) u_chan (
                .clk      (clk),
                .arst_n   (arst_n),
                .wr_en    (wr_en[i]),
                .load_en  (load_en),
                .wr_word  (wr_word),
                .in_code  (in_code[i]),
                .dac_code (dac_code[i])
            );
        end
    endgenerate

    always_comb begin
        top_d      = top_q;
        top_d.live = {NUM_CH{sleep_s}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign code_a = dac_code[CH_A];
    assign code_b = dac_code[CH_B];
    assign live_a = top_q.live[CH_A];
    assign live_b = top_q.live[CH_B];

endmodule

// File: rtl/dbdac_regif_chk.sv
module dbdac_regif_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_n,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              live_a,
    input logic              live_b,
    input logic [DATA_W-1:0] stage_a,
    input logic [DATA_W-1:0] stage_b,
    input logic              load_en,
    input logic [1:0]        wr_en,
    input logic              sleep_s
);

    // R4: without a load the outputs keep their codes
    a_r4_code_hold: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        !load_en |=> ($stable(code_a) && $stable(code_b)));

    // R5: an enabled load leaves both codes equal to the staged words
    a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        load_en |=> (code_a == stage_a && code_b == stage_b));

    // R2 / R3: a staging register moves only on its own write enable
    a_r2_stage_a_hold: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        !wr_en[0] |=> $stable(stage_a));
    a_r3_stage_b_hold: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        !wr_en[1] |=> $stable(stage_b));

    // R6: a low clear holds every register at zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> (code_a == '0 && code_b == '0 && stage_a == '0 && stage_b == '0));

    // R8: sleep drops both live flags
    a_r8_sleep_live: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_s |=> (!live_a && !live_b));

endmodule

bind dbdac_regif dbdac_regif_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_n (clear_n),
    .code_a  (code_a),
    .code_b  (code_b),
    .live_a  (live_a),
    .live_b  (live_b),
    .stage_a (in_code[0]),
    .stage_b (in_code[1]),
    .load_en (load_en),
    .wr_en   (wr_en),
    .sleep_s (sleep_s)
);

// File: tb/dbdac_regif_tb.sv
module dbdac_regif_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int NV         = 9;

    typedef struct packed {
        logic [1:0]   kind;   // 0 write, 1 load pulse, 2 write with load held low
        logic         cs_n;
        logic         sel;
        logic [W-1:0] data;
        logic [W-1:0] exp_a;
        logic [W-1:0] exp_b;
    } vec_t;

    localparam vec_t [0:NV-1] VECS = '{
        vec_t'{2'd0, 1'b0, 1'b0, 12'h123, 12'h000, 12'h000},  // R4 write A
        vec_t'{2'd0, 1'b0, 1'b1, 12'h456, 12'h000, 12'h000},  // R3 write B
        vec_t'{2'd1, 1'b1, 1'b0, 12'h000, 12'h123, 12'h456},  // R5 load both
        vec_t'{2'd0, 1'b1, 1'b0, 12'hABC, 12'h123, 12'h456},  // R2 deselected
        vec_t'{2'd1, 1'b1, 1'b0, 12'h000, 12'h123, 12'h456},  // R2 load shows no change
        vec_t'{2'd0, 1'b0, 1'b0, 12'h0FF, 12'h123, 12'h456},  // R4
        vec_t'{2'd1, 1'b1, 1'b0, 12'h000, 12'h0FF, 12'h456},  // R5
        vec_t'{2'd2, 1'b0, 1'b1, 12'h800, 12'h0FF, 12'h800},  // R7
        vec_t'{2'd2, 1'b0, 1'b0, 12'hFFF, 12'hFFF, 12'h800}   // R7
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_cs_n;
    logic         bus_wr_n;
    logic         bus_sel;
    logic [W-1:0] bus_data;
    logic         load_n;
    logic         clear_n;
    logic         sleep_n;
    logic [W-1:0] code_a;
    logic [W-1:0] code_b;
    logic         live_a;
    logic         live_b;
    logic [7:0]   code8_a;
    logic [7:0]   code8_b;
    logic         live8_a;
    logic         live8_b;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbdac_regif #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_sel(bus_sel), .bus_data(bus_data), .load_n(load_n),
        .clear_n(clear_n), .sleep_n(sleep_n), .code_a(code_a),
        .code_b(code_b), .live_a(live_a), .live_b(live_b)
    );

    dbdac_regif #(.DATA_W(8)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_sel(bus_sel), .bus_data(bus_data[7:0]), .load_n(load_n),
        .clear_n(clear_n), .sleep_n(sleep_n), .code_a(code8_a),
        .code_b(code8_b), .live_a(live8_a), .live_b(live8_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic cs, input logic sel, input logic [W-1:0] data);
        @(negedge clk);
        bus_data = data;
        bus_sel  = sel;
        bus_cs_n = cs;
        bus_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        bus_cs_n = 1'b1;
        bus_wr_n = 1'b1;
        bus_sel  = 1'b0;
        bus_data = '0;
        load_n   = 1'b1;
        clear_n  = 1'b1;
        sleep_n  = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 code_a in reset", code_a, '0);
        check("R1 code_b in reset", code_b, '0);
        check("R1 live in reset", {10'd0, live_a, live_b}, '0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 live after reset", {10'd0, live_a, live_b}, 12'h003);
        check("R1 code_a after reset", code_a, '0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            case (VECS[v].kind)
                2'd0: bus_write(VECS[v].cs_n, VECS[v].sel, VECS[v].data);
                2'd1: pulse_load();
                default: begin
                    @(negedge clk);
                    load_n = 1'b0;
                    repeat (4) @(negedge clk);
                    bus_write(VECS[v].cs_n, VECS[v].sel, VECS[v].data);
                    load_n = 1'b1;
                    repeat (4) @(negedge clk);
                end
            endcase
            check($sformatf("R2-R7 vec%0d code_a", v), code_a, VECS[v].exp_a);
            check($sformatf("R2-R7 vec%0d code_b", v), code_b, VECS[v].exp_b);
            check($sformatf("R10 vec%0d code8_a", v), {4'd0, code8_a}, {4'd0, VECS[v].exp_a[7:0]});
            check($sformatf("R10 vec%0d code8_b", v), {4'd0, code8_b}, {4'd0, VECS[v].exp_b[7:0]});
        end

        // R9: write latency, third edge after wr_n rises
        @(negedge clk);
        load_n   = 1'b0;
        repeat (4) @(negedge clk);
        bus_data = 12'h5C3;
        bus_sel  = 1'b1;
        bus_cs_n = 1'b0;
        bus_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 write not yet at edge 2", code_b, 12'h800);
        @(negedge clk);
        check("R9 write visible at edge 3", code_b, 12'h5C3);
        repeat (2) @(negedge clk);
        bus_cs_n = 1'b1;
        load_n   = 1'b1;
        repeat (4) @(negedge clk);

        // R9: load latency, third edge after load_n falls
        bus_write(1'b0, 1'b0, 12'h321);
        @(negedge clk);
        load_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 load not yet at edge 2", code_a, 12'hFFF);
        @(negedge clk);
        check("R9 load visible at edge 3 a", code_a, 12'h321);
        check("R9 load visible at edge 3 b", code_b, 12'h5C3);
        load_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: sleep keeps codes, drops live
        sleep_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 live in sleep", {10'd0, live_a, live_b}, '0);
        check("R8 code_a kept in sleep", code_a, 12'h321);
        check("R8 code_b kept in sleep", code_b, 12'h5C3);
        sleep_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 live after wake", {10'd0, live_a, live_b}, 12'h003);
        check("R8 code_a after wake", code_a, 12'h321);

        // R6: asynchronous clear, then a write during clear is dropped
        @(negedge clk);
        clear_n = 1'b0;
        #1;
        check("R6 code_a cleared without edge", code_a, '0);
        check("R6 code_b cleared without edge", code_b, '0);
        bus_write(1'b0, 1'b0, 12'h5A5);
        clear_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse_load();
        check("R6 write during clear ignored", code_a, '0);
        check("R6 code8 during clear ignored", {4'd0, code8_a}, '0);

        // R3: after clear, a write to B leaves A alone
        bus_write(1'b0, 1'b1, 12'h0AA);
        pulse_load();
        check("R3 code_b after clear", code_b, 12'h0AA);
        check("R3 code_a untouched", code_a, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule